// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command front end of a byte-wide parallel NOR flash. A host writes command bytes over a strobed bus made of chip enable, write enable, output enable, address and data lines, all active-low strobes sampled on the core clock. The block decodes each command and decides what a read returns: the storage array, identifier bytes, or a status byte. A small array stands in for the real cells.

A two-write block erase starts a timed busy model of the embedded write machine. While it runs, reads return status automatically and a ready output goes low. The erase can be paused and resumed. Failed command sequences raise error flags, and these stay set until software clears them.

The status byte is captured when a read cycle begins and held until that cycle ends. A poll therefore sees one consistent value even if the machine changes state in the middle of the read.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode. Reading address `a` returns its reset content `(a*7+3) mod 256`. `ry_by` is 1 and the status byte is 0x80.
- R2: Command 0xFF is ignored while an erase is running, so reads keep returning status. While the erase is suspended, 0xFF switches reads to the array.
- R3: After command 0x70, every read returns the status byte at any address until another accepted command changes the mode.
- R4: The status byte is captured on the first clock that sees `ce_n` and `oe_n` both low. It is held unchanged until one of them has gone high and a new read begins.
- R5: After command 0x90, in-block offset 0 returns 0x89. Offset 1 returns 0xA7, 0xA6 or 0xAA for a `DENSITY_MBIT` of 4, 8 or 16.
- R6: In identifier mode, in-block offset 2 returns that block's lock bit on bit 0 and offset 3 returns the master lock bit on bit 0. All other bits read 0.
- R7: Status bits 5 and 4 are sticky error flags. Only command 0x50 clears them, and only when no erase is running or suspended.
- R8: Writing 0x20 and then 0xD0 with an address inside block `b` erases block `b`. After `ERASE_CYCLES` clocks every byte of that block reads 0xFF and other blocks are unchanged.
- R9: From the confirm write until the erase completes, reads return status, status bit 7 is 0 and `ry_by` is 0. Both return to 1 on completion.
- R10: If the write after 0x20 is any byte other than 0xD0, bits 5 and 4 are set, nothing is erased and reads return status.
- R11: Command 0xB0 during an erase suspends it. Status bits 7 and 6 read 1, `ry_by` is 1 and the erase timer holds. Command 0xD0 resumes the erase and returns reads to status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; the command is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: block number above the in-block offset |
| din | input | 8 | Command or confirm byte |
| dout | output | 8 | Read data for the current mode |
| ry_by | output | 1 | 1 when ready, 0 while an erase runs |

## Verification
The bench issues 0xFF in the middle of an erase. A design that obeyed it would show array data while the block is busy. The bench also holds one read open across the end of an erase. A design that refreshed the status byte during an open read would show the ready bit rising inside that cycle instead of on the next read. Error flags are tested with a clear issued during a suspend, where a careless decoder would wipe them. A bad confirm byte is also sent, which must set the flags without erasing anything. After a completed erase, the bench reads the bytes on both sides of the erased block to catch an off-by-one in block selection.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int DENSITY_MBIT = 8,
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int ERASE_CYCLES = 40,
  parameter logic [NUM_BLOCKS-1:0] LOCKED_BLOCKS = 4'b0100,
  parameter logic MASTER_LOCK = 1'b1,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ry_by
);
  localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES;
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [7:0] DEV_CODE = (DENSITY_MBIT == 4) ? 8'hA7 :
                                    (DENSITY_MBIT == 16) ? 8'hAA : 8'hA6;

  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STAT} mode_t;

  mode_t            mode;
  logic             we_q, rd_q, setup, busy, susp, err5, err4;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] tgt;
  logic [7:0]       stat_lat, id_byte;
  logic [7:0]       mem [DEPTH];

  wire stb    = !we_q && we_n && !ce_n;
  wire rd_act = !ce_n && !oe_n;
  wire run    = busy && !susp;
  wire done   = run && (cnt == CNT_W'(ERASE_CYCLES - 1));
  wire [7:0] sr = {!run, susp, err5, err4, 4'b0000};
  wire [BLK_W-1:0] blk = addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0] off = addr[OFF_W-1:0];

  assign ry_by = !run;

  always_comb begin
    case (off)
      OFF_W'(0): id_byte = 8'h89;
      OFF_W'(1): id_byte = DEV_CODE;
      OFF_W'(2): id_byte = {7'b0, LOCKED_BLOCKS[blk]};
      OFF_W'(3): id_byte = {7'b0, MASTER_LOCK};
      default:   id_byte = 8'h00;
    endcase
  end

  assign dout = (mode == M_ARRAY) ? mem[addr] :
                (mode == M_ID)    ? id_byte   : stat_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (done) begin
      for (int i = 0; i < DEPTH; i++)
        if (BLK_W'(i >> OFF_W) == tgt) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ARRAY; we_q <= 1'b1; rd_q <= 1'b0; setup <= 1'b0;
      busy <= 1'b0; susp <= 1'b0; err5 <= 1'b0; err4 <= 1'b0;
      cnt <= '0; tgt <= '0; stat_lat <= 8'h80;
    end else begin
      we_q <= we_n;
      rd_q <= rd_act;
      if (rd_act && !rd_q) stat_lat <= sr;
      if (run) begin
        if (done) begin busy <= 1'b0; cnt <= '0; end
        else cnt <= cnt + 1'b1;
      end
      if (stb) begin
        if (setup) begin
          setup <= 1'b0;
          mode  <= M_STAT;
          if (din == 8'hD0) begin
            busy <= 1'b1; cnt <= '0; tgt <= blk;
          end else begin
            err5 <= 1'b1; err4 <= 1'b1;
          end
        end else if (run) begin
          if (din == 8'hB0 && !done) susp <= 1'b1;
          else if (din == 8'h70) mode <= M_STAT;
        end else if (susp) begin
          case (din)
            8'hFF: mode <= M_ARRAY;
            8'h90: mode <= M_ID;
            8'h70: mode <= M_STAT;
            8'hD0: begin susp <= 1'b0; mode <= M_STAT; end
            default: ;
          endcase
        end else begin
          case (din)
            8'hFF: mode <= M_ARRAY;
            8'h90: mode <= M_ID;
            8'h70: mode <= M_STAT;
            8'h50: begin err5 <= 1'b0; err4 <= 1'b0; end
            8'h20: begin setup <= 1'b1; mode <= M_STAT; end
            default: ;
          endcase
        end
      end
    end
  end

  assert_busy_after_confirm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && setup && din == 8'hD0) |=> !ry_by);

  assert_ff_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb && !setup && din == 8'hFF) |=> mode != M_ARRAY);

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && rd_act) |=> $stable(stat_lat));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err5 && !(stb && din == 8'h50 && !setup && !busy)) |=> err5);

  assert_bad_confirm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && setup && din != 8'hD0) |=> (err4 && err5 && ry_by));

  assert_suspend_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && susp) |-> ry_by);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int NB = 4, BB = 16, EC = 40, AW = 6, DEPTH = NB * BB;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic ry_by;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.DENSITY_MBIT(8), .NUM_BLOCKS(NB), .BLOCK_BYTES(BB),
                   .ERASE_CYCLES(EC), .LOCKED_BLOCKS(4'b0100), .MASTER_LOCK(1'b1))
  u_dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
         .addr(addr), .din(din), .dout(dout), .ry_by(ry_by));

  // behavioural reference: 0 array, 1 identifier, 2 status
  int m_mode, m_cnt, m_tgt;
  bit m_busy, m_susp, m_e5, m_e4, m_setup, m_weq, m_rdq;
  int m_lat;
  int m_mem [DEPTH];

  function automatic int m_sr();
    bit r = !(m_busy && !m_susp);
    return (r ? 128 : 0) + (m_susp ? 64 : 0) + (m_e5 ? 32 : 0) + (m_e4 ? 16 : 0);
  endfunction

  function automatic int m_id(int a);
    int o = a % BB, b = a / BB;
    if (o == 0) return 8'h89;
    if (o == 1) return 8'hA6;
    if (o == 2) return (b == 2) ? 1 : 0;
    if (o == 3) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_tgt = 0; m_busy = 0; m_susp = 0; m_e5 = 0; m_e4 = 0;
      m_setup = 0; m_weq = 1; m_rdq = 0; m_lat = 8'h80;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = (i * 7 + 3) % 256;
    end else begin
      bit stb, rd, run, fin;
      int sr;
      stb = !m_weq && we_n && !ce_n;
      rd = !ce_n && !oe_n;
      run = m_busy && !m_susp;
      fin = run && (m_cnt == EC - 1);
      sr = m_sr();
      if (rd && !m_rdq) m_lat = sr;
      m_rdq = rd; m_weq = we_n;
      if (fin) begin
        for (int i = 0; i < BB; i++) m_mem[m_tgt * BB + i] = 255;
        m_busy = 0; m_cnt = 0;
      end else if (run) m_cnt++;
      if (stb) begin
        if (m_setup) begin
          m_setup = 0; m_mode = 2;
          if (din == 8'hD0) begin m_busy = 1; m_cnt = 0; m_tgt = int'(addr) / BB; end
          else begin m_e5 = 1; m_e4 = 1; end
        end else if (run) begin
          if (din == 8'hB0 && !fin) m_susp = 1;
          else if (din == 8'h70) m_mode = 2;
        end else if (m_susp) begin
          if (din == 8'hFF) m_mode = 0;
          else if (din == 8'h90) m_mode = 1;
          else if (din == 8'h70) m_mode = 2;
          else if (din == 8'hD0) begin m_susp = 0; m_mode = 2; end
        end else begin
          if (din == 8'hFF) m_mode = 0;
          else if (din == 8'h90) m_mode = 1;
          else if (din == 8'h70) m_mode = 2;
          else if (din == 8'h50) begin m_e5 = 0; m_e4 = 0; end
          else if (din == 8'h20) begin m_setup = 1; m_mode = 2; end
        end
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    int e;
    e = (m_mode == 0) ? m_mem[addr] : (m_mode == 1) ? m_id(int'(addr)) : m_lat;
    chk((m_mode == 0) ? "R1 model dout" : (m_mode == 1) ? "R5 model dout" : "R3 model dout",
        int'(dout), e);
    chk("R9 model ry_by", int'(ry_by), (m_busy && !m_susp) ? 0 : 1);
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = AW'(a); din = 8'(d); ce_n = 0;
    @(negedge clk); we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = AW'(a); ce_n = 0;
    @(negedge clk); oe_n = 0;
    repeat (3) @(negedge clk);
    v = int'(dout);
    oe_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ry_by && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ry_by), 1);
    rd(5, v);  chk("R1 array byte 5", v, 38);
    wr(0, 8'h90);
    rd(0, v);  chk("R5 manufacturer", v, 8'h89);
    rd(17, v); chk("R5 device code", v, 8'hA6);
    rd(34, v); chk("R6 locked block 2", v, 1);
    rd(18, v); chk("R6 unlocked block 1", v, 0);
    rd(3, v);  chk("R6 master lock", v, 1);
    wr(0, 8'h70);
    rd(9, v);  chk("R3 status idle", v, 8'h80);
    rd(40, v); chk("R3 status any address", v, 8'h80);
    wr(20, 8'h20); wr(20, 8'h33);
    rd(0, v);  chk("R10 bad confirm status", v, 8'hB0);
    wr(0, 8'hFF);
    rd(20, v); chk("R10 no erase", v, 143);
    wr(0, 8'h70);
    rd(0, v);  chk("R7 flags persist", v, 8'hB0);
    wr(0, 8'h50);
    rd(0, v);  chk("R7 clear", v, 8'h80);
    wr(0, 8'h20); wr(0, 8'h00);
    wr(17, 8'h20); wr(17, 8'hD0);
    rd(0, v);  chk("R9 busy status", v, 8'h30);
    chk("R9 ry_by busy", int'(ry_by), 0);
    wr(0, 8'hFF);
    rd(20, v); chk("R2 read array ignored while busy", v, 8'h30);
    wr(0, 8'hB0);
    rd(0, v);  chk("R11 suspended status", v, 8'hF0);
    chk("R11 ready while suspended", int'(ry_by), 1);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    rd(20, v); chk("R2 array while suspended", v, 143);
    wr(0, 8'h70);
    rd(0, v);  chk("R7 clear ignored in suspend", v, 8'hF0);
    wr(0, 8'hD0);
    rd(0, v);  chk("R11 resumed busy", v, 8'h30);
    wait_ready();
    rd(0, v);  chk("R9 done status", v, 8'hB0);
    wr(0, 8'hFF);
    rd(16, v); chk("R8 block first byte", v, 8'hFF);
    rd(31, v); chk("R8 block last byte", v, 8'hFF);
    rd(15, v); chk("R8 lower neighbour", v, 108);
    rd(32, v); chk("R8 upper neighbour", v, 227);
    wr(0, 8'h50);
    wr(50, 8'h20); wr(50, 8'hD0);
    @(negedge clk); ce_n = 0;
    @(negedge clk); oe_n = 0;
    repeat (EC + 10) @(negedge clk);
    chk("R9 ready after erase", int'(ry_by), 1);
    chk("R4 latch held through open read", int'(dout), 8'h00);
    oe_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    rd(0, v);  chk("R4 new read refreshes", v, 8'h80);
    wr(0, 8'hFF);
    rd(60, v); chk("R8 block 3 erased", v, 8'hFF);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule